// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Sequencer

This block sits between a clocked on-chip requester and an external asynchronous static RAM of 131,072 sixteen-bit words. A single request carries a 17-bit word address, write data, a write flag and one enable per byte. The block turns it into the active-low chip-select, write-enable, output-enable and per-byte select sequences the memory expects. It also drives a split data bus: an output word, an output-drive control and an input word. All memory timing is counted in clock cycles. Each count is the nanosecond limit divided by the clock period and rounded up.

The request side is a valid/ready stream. The requester holds `req_valid` and the request fields steady until a cycle in which `req_ready` is high; the request is taken on that clock edge. `req_ready` then stays low until the memory cycle and any bus turnaround gap are over. The response side has no back-pressure: each read produces one single-cycle `rsp_valid` pulse with `rsp_rdata`, which must be taken in that cycle. Writes produce no response.

The sequencer never changes the address while a write strobe is active. It never drives the bus while the memory's outputs are enabled, and it keeps output-enable high for the whole write. After a read it leaves a fixed gap before it accepts the next request.

Top module: `asram_ctrl`

## Requirements
- R1: During and after reset, all five memory strobes are high, `mem_dq_oe` is low, `req_ready` is high and `rsp_valid` is low.
- R2: A read holds chip select and output enable low, with write enable high, for exactly RD_CYC cycles, where RD_CYC = ceil(access ns / clock ns), which is 7 at the defaults. `rsp_valid` rises RD_CYC+1 sampling cycles after the request is driven.
- R3: Read data is captured on the last access cycle and presented with a single-cycle `rsp_valid` pulse. Byte lane 0 is bits 7:0 and lane 1 is bits 15:8. A lane whose enable bit is clear returns 8'h00.
- R4: A write holds write enable low for exactly WP_CYC cycles, which is 6 at the defaults. WP_CYC is the larger of the rounded-up pulse-width and data-setup counts. During the pulse, chip select is low, output enable is high and `mem_dq_oe` is high. The drive starts one cycle before write enable falls and ends one cycle after it rises.
- R5: Each lane is written only when its enable bit is set. `req_be[0]` drives the lower select (bits 7:0) and `req_be[1]` drives the upper select (bits 15:8). A lane whose bit is clear keeps its old contents.
- R6: `mem_addr` never changes while chip select and write enable are both low.
- R7: `mem_dq_oe` is never high while `mem_oe_n` is low. After a read, `req_ready` returns TA_CYC cycles after the `rsp_valid` pulse, where TA_CYC = max(1, ceil(float ns / clock ns)), which is 3 at the defaults.
- R8: A request is taken only in a cycle with `req_ready` high. A request presented while busy has no effect on the memory.
- R9: A request with both enable bits clear still runs a full cycle. It writes no lane, and as a read it returns 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle; request taken this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_addr | output | 17 | Memory word address |
| mem_dq_o | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Enables the bus driver for mem_dq_o |
| mem_dq_i | input | 16 | Data returned from memory |

## Verification
The bound checker watches the following safety rules on every cycle:
- write enable and output enable are never low together;
- the bus is never driven while output enable is low;
- the address holds while a write strobe is active;
- the bus stays undriven in the cycle after output enable rises;
- the read strobe is a single cycle;
- the idle state keeps chip select high.

The bench scenarios cover what needs memory contents and cycle counting:
- the contents left by lane-masked writes;
- the zero-filled disabled lanes on reads;
- the exact pulse, access and turnaround lengths;
- requests made while busy being ignored.

// File: rtl/asram_pkg.sv
package asram_pkg;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned LANES  = WORD_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSET,
    ST_WPUL,
    ST_WEND,
    ST_TURN
  } seq_state_e;

  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int unsigned floor_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int unsigned larger(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_cycle_timer.sv
module asram_cycle_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_lane_capture.sv
module asram_lane_capture #(
  parameter int unsigned NLANE = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [NLANE-1:0]   lane_sel_n,
  input  logic [NLANE*8-1:0] bus_in,
  output logic               out_valid,
  output logic [NLANE*8-1:0] out_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= capture;
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        out_data[g*8 +: 8] <= 8'h00;
      else if (capture)
        out_data[g*8 +: 8] <= lane_sel_n[g] ? 8'h00 : bus_in[g*8 +: 8];
    end
  end
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned AW     = 17,
  parameter int unsigned CW     = 4,
  parameter int unsigned RD_CYC = 7,
  parameter int unsigned WP_CYC = 6,
  parameter int unsigned TA_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  input  logic              tmr_done,
  output logic              tmr_load,
  output logic [CW-1:0]     tmr_val,
  output logic              idle,
  output logic              capture,
  output logic              cs_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [LANES-1:0]  sel_n,
  output logic [AW-1:0]     addr,
  output logic [WORD_W-1:0] dout,
  output logic              drive
);
  localparam logic [CW-1:0] RD_LOAD = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WP_LOAD = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] TA_LOAD = CW'(TA_CYC - 1);

  seq_state_e st_q;
  logic       take;

  assign idle    = (st_q == ST_IDLE);
  assign take    = idle && req_valid;
  assign capture = (st_q == ST_READ) && tmr_done;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (take && !req_write) begin
      tmr_load = 1'b1;
      tmr_val  = RD_LOAD;
    end else if (st_q == ST_WSET) begin
      tmr_load = 1'b1;
      tmr_val  = WP_LOAD;
    end else if (capture) begin
      tmr_load = 1'b1;
      tmr_val  = TA_LOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cs_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      sel_n <= '1;
      addr  <= '0;
      dout  <= '0;
      drive <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid) begin
          addr  <= req_addr;
          cs_n  <= 1'b0;
          sel_n <= ~req_be;
          if (req_write) begin
            dout  <= req_wdata;
            drive <= 1'b1;
            st_q  <= ST_WSET;
          end else begin
            oe_n  <= 1'b0;
            st_q  <= ST_READ;
          end
        end
        ST_READ: if (tmr_done) begin
          cs_n  <= 1'b1;
          oe_n  <= 1'b1;
          sel_n <= '1;
          st_q  <= ST_TURN;
        end
        ST_WSET: begin
          we_n <= 1'b0;
          st_q <= ST_WPUL;
        end
        ST_WPUL: if (tmr_done) begin
          we_n <= 1'b1;
          st_q <= ST_WEND;
        end
        ST_WEND: begin
          cs_n  <= 1'b1;
          sel_n <= '1;
          drive <= 1'b0;
          st_q  <= ST_IDLE;
        end
        ST_TURN: if (tmr_done) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned AW        = 17,
  parameter int unsigned CLK_NS    = 8,
  parameter int unsigned ACCESS_NS = 55,
  parameter int unsigned WPULSE_NS = 45,
  parameter int unsigned DSETUP_NS = 25,
  parameter int unsigned FLOAT_NS  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [WORD_W-1:0] mem_dq_i
);
  localparam int unsigned RD_CYC = floor_one(ns_to_cycles(ACCESS_NS, CLK_NS));
  localparam int unsigned WP_CYC = floor_one(larger(ns_to_cycles(WPULSE_NS, CLK_NS),
                                                    ns_to_cycles(DSETUP_NS, CLK_NS)));
  localparam int unsigned TA_CYC = floor_one(ns_to_cycles(FLOAT_NS, CLK_NS));
  localparam int unsigned MAXC   = larger(RD_CYC, larger(WP_CYC, TA_CYC));
  localparam int unsigned CW     = $clog2(MAXC + 1);

  logic             tmr_load, tmr_done, capture;
  logic [CW-1:0]    tmr_val;
  logic [LANES-1:0] sel_n;

  asram_cycle_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  asram_seq #(
    .AW(AW), .CW(CW), .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .TA_CYC(TA_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be),
    .tmr_done(tmr_done), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .idle(req_ready), .capture(capture),
    .cs_n(mem_cs_n), .we_n(mem_we_n), .oe_n(mem_oe_n), .sel_n(sel_n),
    .addr(mem_addr), .dout(mem_dq_o), .drive(mem_dq_oe)
  );

  asram_lane_capture #(.NLANE(LANES)) u_cap (
    .clk(clk), .rst_n(rst_n), .capture(capture), .lane_sel_n(sel_n),
    .bus_in(mem_dq_i), .out_valid(rsp_valid), .out_data(rsp_rdata)
  );

  assign mem_lb_n = sel_n[0];
  assign mem_ub_n = sel_n[1];
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int unsigned AW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          mem_cs_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic [AW-1:0] mem_addr,
  input logic          mem_dq_oe
);
  p_we_oe_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_cs_n && mem_dq_oe));

  p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_turn_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |=> !mem_dq_oe);

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !mem_cs_n) |-> $stable(mem_addr));

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_idle_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n));
endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_addr(mem_addr), .mem_dq_oe(mem_dq_oe)
);

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;
  localparam int RD = 7;
  localparam int WP = 6;
  localparam int TA = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [16:0] mem_addr;
  logic [15:0] mem_dq_o, mem_dq_i;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  asram_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // Sparse memory model: 64 words tagged with their full address.
  logic [15:0] m_data [64];
  logic [16:0] m_tag  [64];
  initial for (int i = 0; i < 64; i++) begin m_data[i] = '0; m_tag[i] = '0; end

  always_comb begin
    logic [15:0] w;
    w = (m_tag[mem_addr[5:0]] == mem_addr) ? m_data[mem_addr[5:0]] : 16'hDEAD;
    mem_dq_i = 16'hEEEE;
    if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
      if (!mem_lb_n) mem_dq_i[7:0]  = w[7:0];
      if (!mem_ub_n) mem_dq_i[15:8] = w[15:8];
    end
  end

  always @(posedge clk) begin
    if (!mem_cs_n && !mem_we_n && mem_dq_oe && !(mem_lb_n && mem_ub_n)) begin
      if (m_tag[mem_addr[5:0]] != mem_addr) begin
        m_tag[mem_addr[5:0]]  <= mem_addr;
        m_data[mem_addr[5:0]] <= 16'hDEAD;
      end
      if (!mem_lb_n) m_data[mem_addr[5:0]][7:0]  <= mem_dq_o[7:0];
      if (!mem_ub_n) m_data[mem_addr[5:0]][15:8] <= mem_dq_o[15:8];
    end
  end

  // Monitors sampled mid-cycle.
  int wcnt = 0, last_wlen = 0, ocnt = 0, last_olen = 0, viol = 0;
  logic [16:0] prev_addr = '0;
  always @(negedge clk) begin
    if (!mem_we_n) wcnt++;
    else if (wcnt != 0) begin last_wlen = wcnt; wcnt = 0; end
    if (!mem_oe_n && !mem_cs_n && mem_we_n) ocnt++;
    else if (ocnt != 0) begin last_olen = ocnt; ocnt = 0; end
    if (rst_n && mem_dq_oe && !mem_oe_n) viol++;
    if (rst_n && !mem_we_n && !mem_cs_n && mem_addr != prev_addr) viol++;
    prev_addr = mem_addr;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic w, input logic [16:0] a, input logic [15:0] d,
                       input logic [1:0] b, output logic [15:0] rd, output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = b;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    rd = '0;
    if (!w) begin
      while (!rsp_valid && lat < 100) begin @(negedge clk); lat++; end
      rd = rsp_rdata;
    end else begin
      while (!req_ready && lat < 100) begin @(negedge clk); lat++; end
    end
  endtask

  // {write, addr, wdata, be, expected read}
  localparam logic [51:0] VEC [14] = '{
    {1'b1, 17'h00010, 16'h1234, 2'b11, 16'h0000},
    {1'b0, 17'h00010, 16'h0000, 2'b11, 16'h1234},
    {1'b1, 17'h00010, 16'hABCD, 2'b01, 16'h0000},
    {1'b0, 17'h00010, 16'h0000, 2'b11, 16'h12CD},
    {1'b0, 17'h00010, 16'h0000, 2'b10, 16'h1200},
    {1'b0, 17'h00010, 16'h0000, 2'b01, 16'h00CD},
    {1'b1, 17'h1FFFF, 16'hFFFF, 2'b11, 16'h0000},
    {1'b1, 17'h1FFFF, 16'h5A00, 2'b10, 16'h0000},
    {1'b0, 17'h1FFFF, 16'h0000, 2'b11, 16'h5AFF},
    {1'b1, 17'h1FFFF, 16'h0000, 2'b00, 16'h0000},
    {1'b0, 17'h1FFFF, 16'h0000, 2'b11, 16'h5AFF},
    {1'b0, 17'h1FFFF, 16'h0000, 2'b00, 16'h0000},
    {1'b1, 17'h00021, 16'hC3C3, 2'b11, 16'h0000},
    {1'b0, 17'h00021, 16'h0000, 2'b11, 16'hC3C3}
  };

  initial begin
    logic [15:0] rd;
    int lat;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 strobes", {mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'b11111);
    check("R1 drive/ready/valid", {mem_dq_oe, req_ready, rsp_valid}, 3'b010);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {req_ready, mem_cs_n, mem_dq_oe}, 3'b110);

    for (int i = 0; i < 14; i++) begin
      do_op(VEC[i][51], VEC[i][50:34], VEC[i][33:18], VEC[i][17:16], rd, lat);
      if (VEC[i][51]) begin
        check("R4 write pulse length", last_wlen, WP);
      end else begin
        check("R3 R5 R9 read data", rd, VEC[i][15:0]);
        check("R2 read latency", lat, RD + 1);
      end
    end

    // R2: output-enable window of the last read
    check("R2 read strobe length", last_olen, RD);

    // R7: turnaround gap after the read pulse
    do_op(1'b0, 17'h00021, 16'h0, 2'b11, rd, lat);
    lat = 0;
    while (!req_ready && lat < 100) begin @(negedge clk); lat++; end
    check("R7 turnaround cycles", lat, TA);

    // R8: request during a busy read is ignored
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h00021; req_be = 2'b11;
    @(negedge clk);
    req_write = 1'b1; req_addr = 17'h00010; req_wdata = 16'hFFFF;
    check("R8 busy ready low", req_ready, 1'b0);
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    do_op(1'b0, 17'h00010, 16'h0, 2'b11, rd, lat);
    check("R8 busy write ignored", rd, 16'h12CD);

    // R6, R7: monitor counts of address-change and contention hazards
    check("R6 R7 bus and address hazards", viol, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule